// File: doc/BRIEF.md
# Ethernet Receive Frame Error Checker

This block sits on a 64-bit receive packet stream, behind the MAC. It watches each frame from its start beat to its end beat and returns one verdict per frame: an error flag and a six-bit cause vector. The verdict and the cause vector appear combinationally on the same beat that closes the frame. They are held until the next frame opens, so logic downstream can drop or tag the frame without keeping its own copy. The block does not compute the CRC. The CRC result arrives as a flag on the last beat. PHY error characters and link fault arrive as per-beat flags.

The block adds up the bytes of the frame and compares the total against a fixed minimum and a loadable maximum. It picks the length/type field out of the header and compares it against the bytes actually received. A frame cut short by a new start is reported as early-terminated on the beat that cuts it.

Top module: `eth_rx_err_check`

## Requirements
- R1: A beat counts only when `in_valid` is high. Every beat of a frame adds 8 bytes, except the last, which adds 8 minus `in_empty`. Byte k of a beat sits on `in_data[8k+7:8k]`.
- R2: A closed frame of fewer than 64 bytes sets cause bit 0 (short).
- R3: A closed frame longer than the maximum length sets cause bit 1 (long). The maximum resets to 1518. A beat with `cfg_max_we` high loads `cfg_max_val` into it.
- R4: If `in_crc_bad` is high on the closing beat, cause bit 2 (CRC) is set.
- R5: The length/type field is frame byte 12 (upper half) followed by byte 13 (lower half). If it is below 1536 and the frame holds at least 14 bytes, cause bit 3 (length mismatch) is set when the frame length differs from max(field, 46) + 18. Values of 1536 and above are types and are not checked.
- R6: `in_phy_err` or `in_link_fault` high on any beat of the frame, the closing beat included, sets cause bit 4 (PHY).
- R7: A start beat that arrives while a frame is still open reports the open frame on that beat, with cause bit 5 (early termination) alone. That beat then starts a new frame.
- R8: `frm_done`, `frm_cause` and `frm_err` take their values in the cycle of the closing beat and keep them until the next start beat. A start beat that does not close a frame shows zero on all three. `frm_err` is high exactly when some cause bit is set.
- R9: These beats leave the outputs unchanged: beats with `in_valid` low, and end beats that arrive with no frame open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused bytes on the last beat |
| in_data | input | 64 | Beat data, byte 0 in the low lane |
| in_phy_err | input | 1 | PHY error character seen on this beat |
| in_link_fault | input | 1 | Link fault during this beat |
| in_crc_bad | input | 1 | CRC check failed, sampled on the last beat |
| cfg_max_we | input | 1 | Load strobe for the maximum length |
| cfg_max_val | input | 16 | New maximum frame length in bytes |
| frm_done | output | 1 | Verdict present |
| frm_err | output | 1 | Frame errored |
| frm_cause | output | 6 | Per-cause status vector |

## Verification
The bench places frames exactly on the limits: 63, 64, 1518 and 1519 bytes, and 100 bytes under a loaded maximum. A design with an off-by-one compare, or one that takes the last beat as full, flags the wrong member of each pair. Length fields below 46 must be accepted with padding, type values must escape the mismatch check, and frames too short to hold the field must be judged on length alone; a design that gets the padding or the 18-byte overhead wrong shows false mismatches. A PHY flag on the closing beat must still count, a restart in mid-frame must report early termination on that beat and then check the new frame cleanly, and stray end beats and idle cycles must not disturb the held verdict.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam int CAUSE_W = 6;
  localparam int C_SHORT = 0;
  localparam int C_LONG  = 1;
  localparam int C_CRC   = 2;
  localparam int C_LEN   = 3;
  localparam int C_PHY   = 4;
  localparam int C_EARLY = 5;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rxchk_track.sv
// Per-frame state: open flag, running byte count, length field, fault sticky.
module rxchk_track #(
  parameter int DATA_W  = 64,
  parameter int EMP_W   = $clog2(DATA_W/8),
  parameter int CNT_W   = 16,
  parameter int LF_BYTE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [EMP_W-1:0]  in_empty,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_fault,
  output logic              o_start,
  output logic              o_abort,
  output logic              o_fin,
  output logic              o_in_frame,
  output logic              o_phy,
  output logic [CNT_W-1:0]  o_total,
  output logic [15:0]       o_len
);
  localparam int BYTES   = DATA_W / 8;
  localparam int LF_BEAT = LF_BYTE / BYTES;
  localparam int LF_LANE = LF_BYTE % BYTES;
  localparam int LF_CNT  = LF_BEAT * BYTES;

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [15:0]      len_q, len_d;
  logic             phy_q, phy_d;
  logic             ld;
  logic [CNT_W-1:0] base, beat_bytes;
  logic [CNT_W:0]   sum;
  logic             lf_hit;

  always_comb begin
    o_start    = in_valid & in_sop;
    o_abort    = o_start & open_q;
    o_fin      = in_valid & in_eop & (open_q | in_sop);
    o_in_frame = open_q;
    base       = in_sop ? '0 : cnt_q;
    beat_bytes = in_eop ? (CNT_W'(BYTES) - CNT_W'(in_empty)) : CNT_W'(BYTES);
    sum        = {1'b0, base} + {1'b0, beat_bytes};
    o_total    = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    lf_hit     = in_valid & ~in_sop & open_q & (cnt_q == CNT_W'(LF_CNT));
    o_len      = lf_hit ? {in_data[8*LF_LANE +: 8], in_data[8*(LF_LANE+1) +: 8]} : len_q;
    o_phy      = (in_sop ? 1'b0 : phy_q) | in_fault;
    ld         = in_valid & (in_sop | open_q);
    open_d     = ~in_eop;
    cnt_d      = o_total;
    len_d      = o_len;
    phy_d      = o_phy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      phy_q  <= 1'b0;
    end else if (ld) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      phy_q  <= phy_d;
    end
  end
endmodule

// File: rtl/rxchk_eval.sv
// Combinational cause evaluation for a frame closing on the current beat.
module rxchk_eval
  import rxchk_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MIN_LEN  = 64,
  parameter int HDR_B    = 14,
  parameter int FCS_B    = 4,
  parameter int MIN_PAY  = 46,
  parameter int TYPE_MIN = 1536
) (
  input  logic [CNT_W-1:0] total,
  input  logic [15:0]      len_field,
  input  logic             phy,
  input  logic             crc_bad,
  input  logic [15:0]      max_len,
  output cause_t           cause
);
  localparam int OVH = HDR_B + FCS_B;
  localparam int EW  = (CNT_W > 16 ? CNT_W : 16) + 1;

  logic [EW-1:0] want;
  logic [EW-1:0] got;
  logic          is_len;
  logic          have_lf;

  always_comb begin
    got     = EW'(total);
    is_len  = len_field < 16'(TYPE_MIN);
    have_lf = total >= CNT_W'(HDR_B);
    want    = (len_field < 16'(MIN_PAY)) ? EW'(MIN_PAY + OVH) : (EW'(len_field) + EW'(OVH));
    cause          = '0;
    cause[C_SHORT] = total < CNT_W'(MIN_LEN);
    cause[C_LONG]  = got > EW'(max_len);
    cause[C_CRC]   = crc_bad;
    cause[C_LEN]   = have_lf & is_len & (got != want);
    cause[C_PHY]   = phy;
  end
endmodule

// File: rtl/rxchk_hold.sv
// Holds the last verdict until the next frame opens.
module rxchk_hold
  import rxchk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   start,
  input  cause_t cause_in,
  output logic   done,
  output cause_t cause_out
);
  logic   done_q, done_d;
  cause_t cause_q, cause_d;
  logic   en;

  always_comb begin
    en        = fire | start;
    done_d    = fire;
    cause_d   = fire ? cause_in : '0;
    done      = fire | (done_q & ~start);
    cause_out = fire ? cause_in : (start ? '0 : cause_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      cause_q <= '0;
    end else if (en) begin
      done_q  <= done_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/eth_rx_err_check.sv
module eth_rx_err_check
  import rxchk_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int EMP_W       = $clog2(DATA_W/8),
  parameter int CNT_W       = 16,
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN_RST = 1518
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [EMP_W-1:0]    in_empty,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_phy_err,
  input  logic                in_link_fault,
  input  logic                in_crc_bad,
  input  logic                cfg_max_we,
  input  logic [15:0]         cfg_max_val,
  output logic                frm_done,
  output logic                frm_err,
  output logic [CAUSE_W-1:0]  frm_cause
);
  logic             trk_start, trk_abort, trk_fin, trk_in_frame, trk_phy;
  logic [CNT_W-1:0] trk_total;
  logic [15:0]      trk_len;
  logic [15:0]      max_q, max_d;
  cause_t           eval_cause, sel_cause, held_cause;
  logic             fire;

  rxchk_track #(.DATA_W(DATA_W), .EMP_W(EMP_W), .CNT_W(CNT_W), .LF_BYTE(12)) u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_data(in_data), .in_fault(in_phy_err | in_link_fault),
    .o_start(trk_start), .o_abort(trk_abort), .o_fin(trk_fin), .o_in_frame(trk_in_frame),
    .o_phy(trk_phy), .o_total(trk_total), .o_len(trk_len)
  );

  rxchk_eval #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_eval (
    .total(trk_total), .len_field(trk_len), .phy(trk_phy), .crc_bad(in_crc_bad),
    .max_len(max_q), .cause(eval_cause)
  );

  always_comb begin
    fire      = trk_fin | trk_abort;
    sel_cause = eval_cause;
    if (trk_abort) begin
      sel_cause          = '0;
      sel_cause[C_EARLY] = 1'b1;
    end
    max_d     = cfg_max_val;
    frm_cause = held_cause;
    frm_err   = |held_cause;
  end

  rxchk_hold u_hold (
    .clk(clk), .rst_n(rst_n), .fire(fire), .start(trk_start),
    .cause_in(sel_cause), .done(frm_done), .cause_out(held_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          max_q <= 16'(MAX_LEN_RST);
    else if (cfg_max_we) max_q <= max_d;
  end
endmodule

// File: rtl/rxchk_props.sv
module rxchk_props
  import rxchk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_sop,
  input logic               in_eop,
  input logic               in_phy_err,
  input logic               in_link_fault,
  input logic               in_crc_bad,
  input logic               in_frame,
  input logic               frm_done,
  input logic               frm_err,
  input logic [CAUSE_W-1:0] frm_cause
);
  logic closing;
  assign closing = in_valid & in_eop & (in_frame | in_sop) & ~(in_sop & in_frame);

  AST_CRC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    closing && in_crc_bad |-> frm_done && frm_err && frm_cause[C_CRC]); // R4
  AST_PHY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    closing && (in_phy_err || in_link_fault) |-> frm_done && frm_cause[C_PHY]); // R6
  AST_EARLY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && in_frame |-> frm_done && frm_err && (frm_cause == CAUSE_W'(1 << C_EARLY))); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && !in_eop && !in_frame |-> !frm_done && !frm_err && (frm_cause == '0)); // R8
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> (in_valid && (in_sop || (in_eop && in_frame))) || (frm_done && $stable(frm_cause))); // R9
endmodule

bind eth_rx_err_check rxchk_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
  .in_phy_err(in_phy_err), .in_link_fault(in_link_fault), .in_crc_bad(in_crc_bad),
  .in_frame(trk_in_frame), .frm_done(frm_done), .frm_err(frm_err), .frm_cause(frm_cause)
);

// File: tb/eth_rx_err_check_test.sv
module eth_rx_err_check_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop, in_phy_err, in_link_fault, in_crc_bad;
  logic [2:0]  in_empty;
  logic [63:0] in_data;
  logic        cfg_max_we;
  logic [15:0] cfg_max_val;
  logic        frm_done, frm_err;
  logic [5:0]  frm_cause;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  eth_rx_err_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_data(in_data), .in_phy_err(in_phy_err),
    .in_link_fault(in_link_fault), .in_crc_bad(in_crc_bad), .cfg_max_we(cfg_max_we),
    .cfg_max_val(cfg_max_val), .frm_done(frm_done), .frm_err(frm_err), .frm_cause(frm_cause)
  );

  typedef struct packed {
    logic [7:0]  nb;
    logic [2:0]  emp;
    logic [15:0] lenf;
    logic        crc;
    logic [7:0]  phyb;
    logic [5:0]  exp;
  } vec_t;

  // bytes = 8*(nb-1) + 8-emp ; phyb 255 = no PHY flag
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd8,   3'd0, 16'd46,   1'b0, 8'hFF, 6'h00},  // 64, R2 edge
    '{8'd8,   3'd1, 16'd46,   1'b0, 8'hFF, 6'h09},  // 63, short + R5 mismatch
    '{8'd8,   3'd1, 16'h0800, 1'b0, 8'hFF, 6'h01},  // 63, type skips R5
    '{8'd190, 3'd2, 16'd1500, 1'b0, 8'hFF, 6'h00},  // 1518, R3 edge
    '{8'd190, 3'd1, 16'h0800, 1'b0, 8'hFF, 6'h02},  // 1519, R3 long
    '{8'd10,  3'd0, 16'd62,   1'b1, 8'hFF, 6'h04},  // R4 crc
    '{8'd10,  3'd0, 16'd60,   1'b0, 8'hFF, 6'h08},  // R5 mismatch
    '{8'd10,  3'd0, 16'h0800, 1'b0, 8'd3,  6'h10},  // R6 mid-frame
    '{8'd10,  3'd0, 16'h0800, 1'b0, 8'd9,  6'h10},  // R6 on last beat
    '{8'd8,   3'd0, 16'd10,   1'b0, 8'hFF, 6'h00},  // R5 padded
    '{8'd1,   3'd0, 16'd46,   1'b0, 8'hFF, 6'h01},  // 8 bytes, no field
    '{8'd2,   3'd4, 16'd46,   1'b0, 8'hFF, 6'h01},  // 12 bytes, no field
    '{8'd8,   3'd0, 16'd46,   1'b1, 8'd0,  6'h14},  // crc + phy on first beat
    '{8'd190, 3'd0, 16'd1500, 1'b0, 8'hFF, 6'h0A}   // 1520, long + mismatch
  };

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = '0;
    in_phy_err = 1'b0; in_link_fault = 1'b0; in_crc_bad = 1'b0;
  endtask

  task automatic beat(input int b, input int nb, input int emp, input logic [15:0] lenf,
                      input logic crc, input int phyb, input bit sop);
    in_valid = 1'b1; in_sop = sop; in_eop = (b == nb - 1);
    in_empty = (b == nb - 1) ? 3'(emp) : 3'd0;
    in_data = {8{8'(b + 8'h30)}};
    if (b == 1) begin
      in_data[39:32] = lenf[15:8];
      in_data[47:40] = lenf[7:0];
    end
    in_phy_err = (b == phyb);
    in_link_fault = 1'b0;
    in_crc_bad = crc & (b == nb - 1);
  endtask

  task automatic send(input int nb, input int emp, input logic [15:0] lenf, input logic crc,
                      input int phyb, input bit gaps, input logic [5:0] exp, input string rq);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      beat(b, nb, emp, lenf, crc, phyb, b == 0);
      #1;
      if (b == 0 && nb > 1) begin
        chk("R8", "done at start", 16'(frm_done), 16'd0);
        chk("R8", "cause at start", 16'(frm_cause), 16'd0);
      end
      if (b == nb - 1) begin
        chk(rq, "cause", 16'(frm_cause), 16'(exp));
        chk("R8", "err on close", 16'(frm_err), 16'(exp != 0));
        chk("R8", "done on close", 16'(frm_done), 16'd1);
      end
      if (gaps && b < nb - 1) begin
        @(negedge clk);
        idle();
        in_sop = 1'b1;
        #1;
        chk("R9", "idle gap keeps open", 16'(frm_done), 16'd0);
      end
    end
    @(negedge clk);
    idle();
    #1;
    chk("R8", "held done", 16'(frm_done), 16'd1);
    chk("R8", "held cause", 16'(frm_cause), 16'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    in_data = '0;
    cfg_max_we = 1'b0;
    cfg_max_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8", "reset done", 16'(frm_done), 16'd0);
    chk("R8", "reset err", 16'(frm_err), 16'd0);
    chk("R8", "reset cause", 16'(frm_cause), 16'd0);

    for (int i = 0; i < NV; i++)
      send(int'(VECS[i].nb), int'(VECS[i].emp), VECS[i].lenf, VECS[i].crc,
           (VECS[i].phyb == 8'hFF) ? -1 : int'(VECS[i].phyb), 1'b0, VECS[i].exp, "R1/R2/R3/R5 vec");

    // R1: idle cycles inside a frame do not count bytes
    send(8, 0, 16'd46, 1'b0, -1, 1'b1, 6'h00, "R1");

    // R6: link fault alone marks the frame
    @(negedge clk); beat(0, 9, 0, 16'h0800, 1'b0, -1, 1'b1);
    for (int b = 1; b < 9; b++) begin
      @(negedge clk); beat(b, 9, 0, 16'h0800, 1'b0, -1, 1'b0);
      in_link_fault = (b == 5);
      #1;
      if (b == 8) chk("R6", "link fault", 16'(frm_cause), 16'h10);
    end
    @(negedge clk); idle();

    // R9: stray end beat and unqualified start leave the verdict alone
    send(10, 0, 16'd62, 1'b1, -1, 1'b0, 6'h04, "R4");
    @(negedge clk); in_valid = 1'b1; in_eop = 1'b1; in_crc_bad = 1'b0; in_phy_err = 1'b1;
    #1;
    chk("R9", "stray end cause", 16'(frm_cause), 16'h04);
    @(negedge clk); idle(); in_sop = 1'b1;
    #1;
    chk("R9", "invalid start done", 16'(frm_done), 16'd1);
    chk("R9", "invalid start cause", 16'(frm_cause), 16'h04);
    @(negedge clk); idle();

    // R7: restart mid-frame
    for (int b = 0; b < 5; b++) begin
      @(negedge clk); beat(b, 9, 0, 16'd46, 1'b0, -1, b == 0);
    end
    @(negedge clk); beat(0, 8, 0, 16'd46, 1'b0, -1, 1'b1);
    in_phy_err = 1'b1;
    #1;
    chk("R7", "abort done", 16'(frm_done), 16'd1);
    chk("R7", "abort cause", 16'(frm_cause), 16'h20);
    chk("R7", "abort err", 16'(frm_err), 16'd1);
    for (int b = 1; b < 8; b++) begin
      @(negedge clk); beat(b, 8, 0, 16'd46, 1'b0, -1, 1'b0);
    end
    #1;
    chk("R7", "new frame after abort", 16'(frm_cause), 16'h10);
    @(negedge clk); idle();

    // R3: loaded maximum
    @(negedge clk); cfg_max_we = 1'b1; cfg_max_val = 16'd100;
    @(negedge clk); cfg_max_we = 1'b0;
    send(13, 4, 16'h0800, 1'b0, -1, 1'b0, 6'h00, "R3");
    send(13, 3, 16'h0800, 1'b0, -1, 1'b0, 6'h02, "R3");

    // R3: reset restores 1518
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send(190, 2, 16'h0800, 1'b0, -1, 1'b0, 6'h00, "R3");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule